// File: doc/BRIEF.md
# Sticky Event Flags and Event Counter Register Bank

This block gives a CPU a way to see short hardware events that a live status register would miss, and to count events over time. Each bit of a small set of status registers latches high when its event input pulses, even for one cycle, and stays high until software clears it. A separate set of counters each advance by one on every cycle their increment input is high.

One global control register sets two behaviours. The first picks how latched bits are cleared: either a read clears the register it returns, or only an explicit write-one-to-clear changes it. The second picks whether a counter read also zeroes the counter, or whether counters are left alone by reads and wrap from all ones to zero. The control register also holds a self-clearing software reset bit. That bit, together with the active-low reset pin, makes up the global reset.

The CPU side is a plain synchronous bus with an address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. Default map: control at address 0, latched registers at addresses 4 to 7, counters at addresses 8 to 11.

Top module: `status_cnt_bank`

## Requirements
- R1: A 1 on any event input for one or more cycles sets the matching latched bit at the next clock edge. The bit stays 1 after the event input returns to 0.
- R2: With control bit 0 set to 1, a read of a latched register (addresses 4..7, data bits 7:0) returns its value and leaves the register at zero afterwards. Writes to latched registers have no effect in this mode.
- R3: With control bit 0 at 0, reads leave latched registers unchanged. A write clears every bit where the write data holds a 1 and keeps every bit where it holds a 0.
- R4: An event that arrives in the same cycle as a clearing read or write keeps its bit at 1.
- R5: Each counter (addresses 8..11, data bits 15:0) adds one on every cycle its increment input is high. Writes to counter addresses have no effect.
- R6: With control bit 1 at 0, reads leave counters unchanged, and a counter at 0xFFFF goes to 0 on its next increment.
- R7: With control bit 1 set to 1, a counter read returns the value and clears the counter. If an increment arrives in the same cycle, the counter becomes 1.
- R8: Writing 1 to control bit 2 sets the software reset bit for one cycle. That cycle then returns every latched bit, counter, mode bit and the read data to zero, and the reset bit clears itself. Holding the reset pin low does the same, asynchronously.
- R9: Read data updates only on the edge that takes a read strobe and holds its value otherwise. A read of address 0 returns the two mode bits in bits 1:0. A read of an unmapped address returns 0. A read strobe that comes with a write strobe in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset pin |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Registered read data, valid the cycle after rdEn |
| evtIn | input | 32 | Event inputs, 8 per latched register, register 0 in bits 7:0 |
| cntInc | input | 4 | Increment input, one per counter |

## Verification
The assertions assume that the bus issues at most one access per cycle. A read that arrives with a write is treated as absent, so the step and hold properties depend only on the read strobe being low. They also assume that event and increment inputs are clean synchronous levels sampled at the clock edge. The stimulus drives every input at the falling edge, so each one is stable through the rising edge. It never raises both strobes together, and it applies the reset pin only while the bus is idle.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;
  localparam int CTRL_LAT_BIT = 0;
  localparam int CTRL_CNT_BIT = 1;
  localparam int CTRL_SWR_BIT = 2;

  typedef struct packed {
    logic ctrlRead;
    logic latRead;
    logic latWrite;
    logic cntRead;
  } bankStrobe_t;
endpackage

// File: rtl/sc_bank_ctrl.sv
module sc_bank_ctrl
  import sc_bank_pkg::*;
#(
  parameter int NUM_LAT  = 4,
  parameter int NUM_CNT  = 4,
  parameter int ADDR_W   = 4,
  parameter int LAT_BASE = 4,
  parameter int CNT_BASE = 8,
  localparam int LAT_IDX_W = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1,
  localparam int CNT_IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [2:0]           ctrlBits,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output bankStrobe_t          strb,
  output logic [LAT_IDX_W-1:0] latSel,
  output logic [CNT_IDX_W-1:0] cntSel,
  output logic                 latClrMode,
  output logic                 cntClrMode,
  output logic                 swRst
);
  logic latHit, cntHit, ctrlHit, doRead;
  logic [ADDR_W-1:0] latOff, cntOff;

  always_comb begin
    latOff  = addr - ADDR_W'(LAT_BASE);
    cntOff  = addr - ADDR_W'(CNT_BASE);
    latHit  = (addr >= ADDR_W'(LAT_BASE)) && (addr < ADDR_W'(LAT_BASE + NUM_LAT));
    cntHit  = (addr >= ADDR_W'(CNT_BASE)) && (addr < ADDR_W'(CNT_BASE + NUM_CNT));
    ctrlHit = (addr == '0);
    doRead  = rdEn && !wrEn && !swRst;
    latSel  = latOff[LAT_IDX_W-1:0];
    cntSel  = cntOff[CNT_IDX_W-1:0];
    strb.ctrlRead = doRead && ctrlHit;
    strb.latRead  = doRead && latHit;
    strb.latWrite = wrEn && !swRst && latHit;
    strb.cntRead  = doRead && cntHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latClrMode <= 1'b0;
      cntClrMode <= 1'b0;
      swRst      <= 1'b0;
    end else if (swRst) begin
      latClrMode <= 1'b0;
      cntClrMode <= 1'b0;
      swRst      <= 1'b0;
    end else if (wrEn && ctrlHit) begin
      latClrMode <= ctrlBits[CTRL_LAT_BIT];
      cntClrMode <= ctrlBits[CTRL_CNT_BIT];
      swRst      <= ctrlBits[CTRL_SWR_BIT];
    end
  end
endmodule

// File: rtl/sc_bank_data.sv
module sc_bank_data
  import sc_bank_pkg::*;
#(
  parameter int NUM_LAT = 4,
  parameter int LAT_W   = 8,
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  localparam int LAT_IDX_W = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1,
  localparam int CNT_IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bankStrobe_t                strb,
  input  logic [LAT_IDX_W-1:0]       latSel,
  input  logic [CNT_IDX_W-1:0]       cntSel,
  input  logic                       latClrMode,
  input  logic                       cntClrMode,
  input  logic                       swRst,
  input  logic                       rdEn,
  input  logic [LAT_W-1:0]           clrMask,
  input  logic [NUM_LAT*LAT_W-1:0]   evtIn,
  input  logic [NUM_CNT-1:0]         cntInc,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_LAT*LAT_W-1:0]   latFlat,
  output logic [NUM_CNT*CNT_W-1:0]   cntFlat
);
  logic [LAT_W-1:0] latReg [NUM_LAT];
  logic [CNT_W-1:0] cntReg [NUM_CNT];
  logic [DATA_W-1:0] rdNext;

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
    logic [LAT_W-1:0] clrBits;
    always_comb begin
      clrBits = '0;
      if (latSel == LAT_IDX_W'(i)) begin
        if (strb.latRead && latClrMode)   clrBits = '1;
        if (strb.latWrite && !latClrMode) clrBits = clrMask;
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      latReg[i] <= '0;
      else if (swRst) latReg[i] <= '0;
      else            latReg[i] <= (latReg[i] & ~clrBits) | evtIn[i*LAT_W +: LAT_W];
    end
    assign latFlat[i*LAT_W +: LAT_W] = latReg[i];
  end

  for (genvar j = 0; j < NUM_CNT; j++) begin : g_cnt
    logic clrNow;
    assign clrNow = strb.cntRead && cntClrMode && (cntSel == CNT_IDX_W'(j));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       cntReg[j] <= '0;
      else if (swRst)  cntReg[j] <= '0;
      else if (clrNow) cntReg[j] <= CNT_W'(cntInc[j]);
      else             cntReg[j] <= cntReg[j] + CNT_W'(cntInc[j]);
    end
    assign cntFlat[j*CNT_W +: CNT_W] = cntReg[j];
  end

  always_comb begin
    rdNext = '0;
    if (strb.ctrlRead) rdNext[1:0] = {cntClrMode, latClrMode};
    if (strb.latRead)  rdNext[LAT_W-1:0] = latReg[latSel];
    if (strb.cntRead)  rdNext[CNT_W-1:0] = cntReg[cntSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdData <= '0;
    else if (swRst) rdData <= '0;
    else if (rdEn)  rdData <= rdNext;
  end
endmodule

// File: rtl/status_cnt_bank.sv
module status_cnt_bank
  import sc_bank_pkg::*;
#(
  parameter int NUM_LAT  = 4,
  parameter int LAT_W    = 8,
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int LAT_BASE = 4,
  parameter int CNT_BASE = 8,
  localparam int LAT_IDX_W = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1,
  localparam int CNT_IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output logic [DATA_W-1:0]        rdData,
  input  logic [NUM_LAT*LAT_W-1:0] evtIn,
  input  logic [NUM_CNT-1:0]       cntInc
);
  bankStrobe_t strb;
  logic [LAT_IDX_W-1:0] latSel;
  logic [CNT_IDX_W-1:0] cntSel;
  logic latClrMode, cntClrMode, swRst;
  logic [NUM_LAT*LAT_W-1:0] latFlat;
  logic [NUM_CNT*CNT_W-1:0] cntFlat;

  sc_bank_ctrl #(
    .NUM_LAT(NUM_LAT), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W),
    .LAT_BASE(LAT_BASE), .CNT_BASE(CNT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ctrlBits(wrData[2:0]),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb), .latSel(latSel), .cntSel(cntSel),
    .latClrMode(latClrMode), .cntClrMode(cntClrMode), .swRst(swRst)
  );

  sc_bank_data #(
    .NUM_LAT(NUM_LAT), .LAT_W(LAT_W), .NUM_CNT(NUM_CNT),
    .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .latSel(latSel), .cntSel(cntSel),
    .latClrMode(latClrMode), .cntClrMode(cntClrMode), .swRst(swRst),
    .rdEn(rdEn && !wrEn), .clrMask(wrData[LAT_W-1:0]), .evtIn(evtIn),
    .cntInc(cntInc), .rdData(rdData), .latFlat(latFlat), .cntFlat(cntFlat)
  );
endmodule

// File: rtl/sc_bank_chk.sv
module sc_bank_chk #(
  parameter int NUM_LAT = 4,
  parameter int LAT_W   = 8,
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     rdEn,
  input logic                     wrEn,
  input logic                     swRst,
  input logic [NUM_LAT*LAT_W-1:0] evtIn,
  input logic [NUM_CNT-1:0]       cntInc,
  input logic [DATA_W-1:0]        rdData,
  input logic [NUM_LAT*LAT_W-1:0] latFlat,
  input logic [NUM_CNT*CNT_W-1:0] cntFlat
);
  // R1: an event input sets its flag at the next edge
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && (|evtIn)) |=> ((latFlat & $past(evtIn)) == $past(evtIn)));

  // R3: flags only fall through a bus access
  a_r3_sticky_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && !rdEn && !wrEn) |=> ((latFlat & $past(latFlat)) == $past(latFlat)));

  // R5: without a read each counter steps by its increment
  for (genvar j = 0; j < NUM_CNT; j++) begin : g_step
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
      (!swRst && !rdEn) |=>
        (cntFlat[j*CNT_W +: CNT_W] ==
         $past(cntFlat[j*CNT_W +: CNT_W]) + CNT_W'($past(cntInc[j]))));
  end

  // R8: software reset clears everything and itself
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (latFlat == '0 && cntFlat == '0 && rdData == '0 && !swRst));

  // R9: read data holds without a read strobe
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !swRst) |=> $stable(rdData));
endmodule

bind status_cnt_bank sc_bank_chk #(
  .NUM_LAT(NUM_LAT), .LAT_W(LAT_W), .NUM_CNT(NUM_CNT),
  .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .swRst(swRst),
  .evtIn(evtIn), .cntInc(cntInc), .rdData(rdData),
  .latFlat(latFlat), .cntFlat(cntFlat)
);

// File: tb/status_cnt_bank_test.sv
module status_cnt_bank_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] rdData;
  logic [31:0] evtIn = '0;
  logic [3:0] cntInc = '0;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R8";

  // behavioural reference state
  int mLat[4];
  int mCnt[4];
  bit mLatMode = 0, mCntMode = 0, mSw = 0;
  int mRd = 0;

  always #5 clk = ~clk;

  status_cnt_bank uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .evtIn(evtIn), .cntInc(cntInc)
  );

  function automatic int peek(int a);
    if (a == 0) return (int'(mCntMode) << 1) | int'(mLatMode);
    if (a >= 4 && a < 8) return mLat[a-4];
    if (a >= 8 && a < 12) return mCnt[a-8];
    return 0;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 4; i++) begin mLat[i] = 0; mCnt[i] = 0; end
    mLatMode = 0; mCntMode = 0; mSw = 0; mRd = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) clearModel();
    else if (mSw) clearModel();
    else begin
      bit doRd;
      int a;
      a = int'(addr);
      doRd = rdEn && !wrEn;
      if (doRd) mRd = peek(a);
      for (int i = 0; i < 4; i++) begin
        int clr;
        clr = 0;
        if (doRd && a == 4 + i && mLatMode) clr = 'hFF;
        if (wrEn && a == 4 + i && !mLatMode) clr = int'(wrData[7:0]);
        mLat[i] = (mLat[i] & ~clr & 'hFF) | int'(evtIn[i*8 +: 8]);
      end
      for (int j = 0; j < 4; j++) begin
        if (doRd && a == 8 + j && mCntMode) mCnt[j] = int'(cntInc[j]);
        else mCnt[j] = (mCnt[j] + int'(cntInc[j])) & 'hFFFF;
      end
      if (wrEn && a == 0) begin
        mLatMode = wrData[0]; mCntMode = wrData[1]; mSw = wrData[2];
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    checks++;
    if (int'(rdData) != mRd) begin
      errors++;
      $display("FAIL %s model compare: rdData=%h expected=%h", curReq, rdData, mRd[15:0]);
    end
  end

  task automatic check(string req, int exp);
    checks++;
    if (int'(rdData) != exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected=%h", req, rdData, exp[15:0]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = 4'(a); wrData = 16'(d); wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readChk(int a, int exp, string req);
    @(negedge clk); addr = 4'(a); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    check(req, exp);
  endtask

  task automatic pulseEvt(int idx, int v);
    @(negedge clk); evtIn[idx*8 +: 8] = 8'(v);
    @(negedge clk); evtIn = '0;
  endtask

  task automatic incFor(int j, int n);
    @(negedge clk); cntInc[j] = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk); cntInc[j] = 1'b0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    check("R8", 0);
    rstN = 1'b1;
    curReq = "R8";
    readChk(0, 0, "R8");
    readChk(4, 0, "R8");
    curReq = "R9";
    readChk(15, 0, "R9");
    readChk(3, 0, "R9");

    curReq = "R1";
    pulseEvt(0, 'h08);
    pulseEvt(2, 'h81);
    idle(2);
    readChk(4, 'h08, "R1");
    readChk(4, 'h08, "R3");
    readChk(6, 'h81, "R1");
    curReq = "R3";
    wr(6, 'h01);
    readChk(6, 'h80, "R3");
    wr(6, 'h00);
    readChk(6, 'h80, "R3");

    curReq = "R2";
    wr(0, 1);
    readChk(0, 1, "R9");
    pulseEvt(1, 'h3C);
    readChk(5, 'h3C, "R2");
    readChk(5, 0, "R2");
    wr(4, 'hFF);
    readChk(4, 'h08, "R2");
    readChk(4, 0, "R2");

    curReq = "R4";
    pulseEvt(3, 'h10);
    @(negedge clk); addr = 4'd7; rdEn = 1'b1; evtIn[31:24] = 8'h10;
    @(negedge clk); rdEn = 1'b0; evtIn = '0;
    check("R4", 'h10);
    readChk(7, 'h10, "R4");
    readChk(7, 0, "R4");
    wr(0, 0);
    pulseEvt(3, 'h02);
    @(negedge clk); addr = 4'd7; wrData = 16'h0002; wrEn = 1'b1; evtIn[31:24] = 8'h02;
    @(negedge clk); wrEn = 1'b0; evtIn = '0;
    readChk(7, 'h02, "R4");

    curReq = "R5";
    incFor(0, 5);
    readChk(8, 5, "R5");
    readChk(8, 5, "R6");
    wr(8, 'h1234);
    readChk(8, 5, "R5");

    curReq = "R6";
    incFor(1, 65535);
    readChk(9, 'hFFFF, "R6");
    incFor(1, 1);
    readChk(9, 0, "R6");

    curReq = "R7";
    wr(0, 2);
    incFor(2, 3);
    readChk(10, 3, "R7");
    readChk(10, 0, "R7");
    incFor(3, 4);
    @(negedge clk); addr = 4'd11; rdEn = 1'b1; cntInc[3] = 1'b1;
    @(negedge clk); rdEn = 1'b0; cntInc = '0;
    check("R7", 4);
    readChk(11, 1, "R7");

    curReq = "R9";
    idle(3);
    check("R9", 1);

    curReq = "R8";
    pulseEvt(0, 'hFF);
    incFor(0, 6);
    wr(0, 'h6);
    idle(1);
    readChk(0, 0, "R8");
    readChk(4, 0, "R8");
    readChk(8, 0, "R8");
    pulseEvt(2, 'h44);
    incFor(2, 2);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readChk(6, 0, "R8");
    readChk(10, 0, "R8");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule